// File: doc/BRIEF.md
# Buffered Serial Slave Channel with Gapless Transfers

This block is the slave end of a four-wire style serial link in which an external master supplies the serial clock. It exchanges 8-bit words, most significant bit first. The clock idles low. The outgoing bit changes after a falling clock edge and the incoming bit is taken on a rising edge. The serial clock and the incoming data pass through a two-stage synchronizer into the system clock domain, and the edges are found there. The system clock must run at least four times faster than the serial clock.

Software sees one data register. When the channel is idle, a write goes straight into the shift register. When a word is loaded or already shifting, the write is held in a one-word buffer. At the end of a word, the buffered word moves into the shift register on the same edge, so the master can clock word after word with no gap. Each completed word that was really loaded leaves its received value readable on the register port. If no new word is waiting when a word ends, the slave sends the last word again. That repeated word counts as neither a transfer nor a reception.

One interrupt-mode input selects when the single-cycle interrupt pulse fires: either at the end of each transfer, or when a word moves into the shift register and leaves the buffer empty. The input is evaluated live, so it may be changed while a transfer is running.

Top module: `spi_dbuf_slave`

## Requirements
- R1: A start pulse sets chanOn and a stop pulse clears it; stop wins if both arrive together. While chanOn is 0, writes and serial clock edges have no effect. Stop clears busy and bufFull.
- R2: sdOut presents the transmit word most significant bit first. The first bit appears as soon as the word is loaded, and each later bit appears after a falling serial clock edge.
- R3: sdIn is sampled on rising serial clock edges, most significant bit first. After the eighth rising edge of a loaded word, the received word can be read on rdData.
- R4: A write while chanOn is 1, no word is loaded and no word is part-way through goes straight into the shift register; bufFull stays 0.
- R5: A write while a word is loaded or shifting goes into the buffer and sets bufFull. A second write before handoff silently replaces the buffered word.
- R6: rdData returns the buffered transmit word while bufFull is 1 and the last received word otherwise. Reading has no side effect.
- R7: On the eighth rising edge of a word, a buffered word moves into the shift register and bufFull clears. The next word follows with no gap.
- R8: busy is 1 from the first rising edge of a loaded word until its eighth rising edge, and it is 0 between words.
- R9: With intMode 0, irq pulses for one cycle at the end of each loaded word.
- R10: With intMode 1, irq pulses when a word enters the shift register, either from the buffer or by a direct write, and not at the end of a word. The value of intMode at the moment of the event decides.
- R11: If a word ends with the buffer empty, the last transmit word is repeated. During the repeat, busy stays 0, no irq fires and rdData is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Channel enable pulse |
| stopStb | input | 1 | Channel disable pulse |
| intMode | input | 1 | 0: irq at end of word, 1: irq when a word enters the shift register |
| wrEn | input | 1 | Data register write strobe |
| wrData | input | 8 | Transmit word to write |
| rdData | output | 8 | Buffered transmit word or last received word |
| chanOn | output | 1 | Channel enabled |
| busy | output | 1 | Word transfer in progress |
| bufFull | output | 1 | Buffer holds a word not yet handed off |
| irq | output | 1 | Single-cycle interrupt pulse |
| sclkIn | input | 1 | Serial clock from the master |
| sdIn | input | 1 | Serial data from the master |
| sdOut | output | 1 | Serial data to the master |

## Verification
The bench drives the three serial pins as a master would.

- **Overwrite.** It writes twice before a handoff. A design that kept the first word, or raised an error, shows the wrong word on rdData and on the wire.
- **Back-to-back words.** It clocks words back to back. A design that lost the handoff would send a stale or shifted word.
- **Mode switching.** It switches intMode between words. Counting pulses then exposes a design that latched the mode at the start of the word, or that fired in both modes.
- **Underrun.** It lets the buffer run dry. A design that did not repeat the last word, raised busy, or overwrote the received word fails there.
- **Disabled channel.** It writes and clocks while the channel is off. A design that ignored the enable would load or receive data.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int WORD_BITS = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic loadDirect;
    logic loadBuf;
    logic loadRepeat;
    logic bufWrite;
    logic shiftOut;
    logic sampleIn;
    logic captureRx;
  } strobe_t;
endpackage

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
  import spi_dbuf_pkg::*;
#(
  parameter int WORD_W = WORD_BITS,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    stopStb,
  input  logic    intMode,
  input  logic    wrEn,
  input  logic    sclkIn,
  output logic    chanOn,
  output logic    busy,
  output logic    bufFull,
  output logic    irq,
  output strobe_t str
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_N:0]  sclkPipe;
  logic [CNT_W-1:0] bitCnt;
  logic             loaded;
  logic             rise, fall, endWord;
  strobe_t          s;

  always_comb begin
    rise    = sclkPipe[SYNC_N-1] & ~sclkPipe[SYNC_N];
    fall    = ~sclkPipe[SYNC_N-1] & sclkPipe[SYNC_N];
    endWord = chanOn && rise && (bitCnt == LAST);
    s.loadDirect = chanOn && !stopStb && wrEn && !loaded && (bitCnt == '0) && !rise;
    s.bufWrite   = chanOn && !stopStb && wrEn && !s.loadDirect;
    s.loadBuf    = endWord && bufFull;
    s.loadRepeat = endWord && !bufFull;
    s.shiftOut   = chanOn && fall;
    s.sampleIn   = chanOn && rise;
    s.captureRx  = endWord && loaded;
  end

  assign str = s;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0;
      chanOn   <= 1'b0;
      loaded   <= 1'b0;
      bitCnt   <= '0;
      busy     <= 1'b0;
      bufFull  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_N-1:0], sclkIn};
      if (stopStb) begin
        chanOn  <= 1'b0;
        loaded  <= 1'b0;
        bitCnt  <= '0;
        busy    <= 1'b0;
        bufFull <= 1'b0;
        irq     <= 1'b0;
      end else begin
        if (startStb) chanOn <= 1'b1;
        if (chanOn && rise) bitCnt <= endWord ? '0 : bitCnt + CNT_W'(1);
        if (s.loadDirect || s.loadBuf) loaded <= 1'b1;
        else if (s.loadRepeat)         loaded <= 1'b0;
        if (endWord) busy <= 1'b0;
        else if (chanOn && rise && (bitCnt == '0) && loaded) busy <= 1'b1;
        if (s.bufWrite)     bufFull <= 1'b1;
        else if (s.loadBuf) bufFull <= 1'b0;
        irq <= chanOn && (intMode ? (s.loadBuf || s.loadDirect) : s.captureRx);
      end
    end
  end

  assert_busy_on_R1: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> chanOn);
  assert_stop_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> (!busy && !bufFull && !chanOn));
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chanOn && bufFull && !stopStb && !endWord) |=> bufFull);
  assert_busy_loaded_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(loaded));
  assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(chanOn));
endmodule

// File: rtl/spi_dbuf_dpath.sv
module spi_dbuf_dpath
  import spi_dbuf_pkg::*;
#(
  parameter int WORD_W = WORD_BITS,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic              bufFull,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdIn,
  output logic [WORD_W-1:0] rdData,
  output logic              sdOut
);
  logic [SYNC_N-1:0] sdPipe;
  logic [WORD_W-1:0] bufWord, txShift, lastTx, rxShift, rxWord;
  logic              outBit;
  logic              sdBit;

  assign sdBit  = sdPipe[SYNC_N-1];
  assign sdOut  = outBit;
  assign rdData = bufFull ? bufWord : rxWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdPipe  <= '0;
      bufWord <= '0;
      txShift <= '0;
      lastTx  <= '0;
      rxShift <= '0;
      rxWord  <= '0;
      outBit  <= 1'b0;
    end else begin
      sdPipe <= {sdPipe[SYNC_N-2:0], sdIn};
      if (str.bufWrite) bufWord <= wrData;
      if (str.loadDirect) begin
        txShift <= {wrData[WORD_W-2:0], 1'b0};
        outBit  <= wrData[WORD_W-1];
        lastTx  <= wrData;
      end else if (str.loadBuf) begin
        txShift <= bufWord;
        lastTx  <= bufWord;
      end else if (str.loadRepeat) begin
        txShift <= lastTx;
      end else if (str.shiftOut) begin
        outBit  <= txShift[WORD_W-1];
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      end
      if (str.sampleIn)  rxShift <= {rxShift[WORD_W-2:0], sdBit};
      if (str.captureRx) rxWord  <= {rxShift[WORD_W-2:0], sdBit};
    end
  end

  assert_sdout_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(str.shiftOut || str.loadDirect) |=> $stable(sdOut));
  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !str.captureRx |=> $stable(rxWord));
endmodule

// File: rtl/spi_dbuf_slave.sv
module spi_dbuf_slave
  import spi_dbuf_pkg::*;
#(
  parameter int WORD_W = WORD_BITS,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              intMode,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              chanOn,
  output logic              busy,
  output logic              bufFull,
  output logic              irq,
  input  logic              sclkIn,
  input  logic              sdIn,
  output logic              sdOut
);
  strobe_t str;

  spi_dbuf_ctrl #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .intMode(intMode), .wrEn(wrEn), .sclkIn(sclkIn), .chanOn(chanOn),
    .busy(busy), .bufFull(bufFull), .irq(irq), .str(str)
  );

  spi_dbuf_dpath #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_dpath (
    .clk(clk), .rstN(rstN), .str(str), .bufFull(bufFull), .wrData(wrData),
    .sdIn(sdIn), .rdData(rdData), .sdOut(sdOut)
  );
endmodule

// File: tb/spi_dbuf_slave_tb.sv
module spi_dbuf_slave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, startStb, stopStb, intMode, wrEn, sclkIn, sdIn;
  logic [7:0] wrData, rdData;
  logic       chanOn, busy, bufFull, irq, sdOut;

  spi_dbuf_slave u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .intMode(intMode), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .chanOn(chanOn), .busy(busy), .bufFull(bufFull), .irq(irq),
    .sclkIn(sclkIn), .sdIn(sdIn), .sdOut(sdOut)
  );

  int   nChk = 0, nFail = 0, irqCnt = 0;
  logic chanRef;
  logic busyMid;
  logic [7:0] miso;

  task automatic chkEq(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference for the enable state, compared every clock (R1)
  always @(posedge clk) begin
    if (!rstN)         chanRef <= 1'b0;
    else if (stopStb)  chanRef <= 1'b0;
    else if (startStb) chanRef <= 1'b1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (irq) irqCnt++;
      nChk++;
      if (chanOn !== chanRef) begin
        nFail++;
        $display("FAIL R1 chanOn actual=%0b expected=%0b", chanOn, chanRef);
      end
    end
  end

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic doStart();
    @(negedge clk); startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doStop();
    @(negedge clk); stopStb = 1'b1;
    @(negedge clk); stopStb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mosi, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sdIn = mosi[i];
      repeat (HALF - 1) @(negedge clk);
      got[i] = sdOut;
      sclkIn = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == 4) busyMid = busy;
      sclkIn = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0; startStb = 1'b0; stopStb = 1'b0; intMode = 1'b0;
    wrEn = 1'b0; wrData = '0; sclkIn = 1'b0; sdIn = 1'b0; busyMid = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 reset chanOn", chanOn, 0);
    chkEq("R8 reset busy", busy, 0);
    chkEq("R5 reset bufFull", bufFull, 0);
    chkEq("R6 reset rdData", rdData, 0);
    chkEq("R2 reset sdOut", sdOut, 0);

    // R1: channel off ignores writes and clocks
    doWrite(8'h5A);
    chkEq("R1 write while off bufFull", bufFull, 0);
    xfer(8'hFF, miso);
    chkEq("R1 clock while off rdData", rdData, 8'h00);
    chkEq("R1 clock while off irq", irqCnt, 0);

    doStart();
    chkEq("R1 start chanOn", chanOn, 1);

    // R4: direct load
    doWrite(8'hA5);
    chkEq("R4 direct load bufFull", bufFull, 0);
    chkEq("R2 first bit before clock", sdOut, 1);
    chkEq("R9 no irq on load in mode 0", irqCnt, 0);

    // R5/R6: buffer and overwrite
    doWrite(8'h3C);
    chkEq("R5 buffer write bufFull", bufFull, 1);
    chkEq("R6 rdData shows buffer", rdData, 8'h3C);
    doWrite(8'hC3);
    chkEq("R5 overwrite rdData", rdData, 8'hC3);

    xfer(8'h96, miso);
    chkEq("R2 master got first word", miso, 8'hA5);
    chkEq("R3 received word", rdData, 8'h96);
    chkEq("R7 bufFull cleared", bufFull, 0);
    chkEq("R8 busy mid word", busyMid, 1);
    chkEq("R8 busy between words", busy, 0);
    chkEq("R9 end irq mode 0", irqCnt, 1);

    // R10: mode 1, handoff interrupt
    doWrite(8'h81);
    intMode = 1'b1;
    xfer(8'h0F, miso);
    chkEq("R7 gapless second word", miso, 8'hC3);
    chkEq("R10 irq on handoff only", irqCnt, 2);
    chkEq("R3 second received", rdData, 8'h0F);

    // R9/R10: mode changed during operation
    intMode = 1'b0;
    xfer(8'hE7, miso);
    chkEq("R7 third word", miso, 8'h81);
    chkEq("R10 new mode governs end irq", irqCnt, 3);
    chkEq("R3 third received", rdData, 8'hE7);

    // R11: underrun repeats last word
    xfer(8'h55, miso);
    chkEq("R11 repeated word", miso, 8'h81);
    chkEq("R11 busy low on repeat", busyMid, 0);
    chkEq("R11 no irq on repeat", irqCnt, 3);
    chkEq("R11 rdData kept", rdData, 8'hE7);

    // R10: direct load in mode 1
    intMode = 1'b1;
    doWrite(8'h42);
    chkEq("R10 irq on direct load", irqCnt, 4);
    chkEq("R4 direct after repeat bufFull", bufFull, 0);
    chkEq("R2 new first bit", sdOut, 0);
    xfer(8'h24, miso);
    chkEq("R2 word after repeat", miso, 8'h42);
    chkEq("R10 no end irq in mode 1", irqCnt, 4);
    chkEq("R3 fourth received", rdData, 8'h24);

    // R1: stop clears state and blocks activity
    doWrite(8'h77);
    doWrite(8'h11);
    chkEq("R5 buffered before stop", bufFull, 1);
    doStop();
    chkEq("R1 stop chanOn", chanOn, 0);
    chkEq("R1 stop bufFull", bufFull, 0);
    chkEq("R1 stop busy", busy, 0);
    chkEq("R6 rdData after stop", rdData, 8'h24);
    xfer(8'hAA, miso);
    chkEq("R1 off no reception", rdData, 8'h24);
    chkEq("R1 off no irq", irqCnt, 5);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule